// File: doc/BRIEF.md
# USB Full-Speed Link State Monitor

This block follows the state of a device-side USB Full-Speed link. It takes the VBUS sense level and the decoded line condition (SE0, idle J, or anything else) and keeps a 3-bit link state. It also emits a single-cycle event pulse whenever the link connects, disconnects, is reset by the host, suspends, resumes or loses the host. It runs on the 48 MHz USB clock. Every time threshold is a parameter counted in clock cycles. The defaults are 144 cycles (3 µs) of SE0 for a reset, 144000 cycles (3 ms) of idle J for a suspend, and 196608 cycles (4.096 ms) without a start-of-frame for the host-lost condition.

The sense level and both line-condition inputs pass through a two-flop synchronizer before the state machine or any timer sees them. A separate override pair can replace the sense level directly, and the effective sense level is brought out as a status bit. The protocol engine supplies a one-cycle valid-SOF strobe on the same clock. That strobe feeds a watchdog that sets a sticky host-lost flag. The link-reset pulse is the signal the surrounding logic uses to force its stored device address back to zero.

Top module: `usb_link_monitor`

## Requirements
- R1: The link state output uses code 0 for disconnected, 1 for powered, 2 for powered-suspend, 3 for active and 4 for suspended, and never shows another code. After reset it reads 0 with no event pulse and the host-lost flag clear.
- R2: While the effective sense level is low, the state goes to 0 and a disconnect pulse fires on entry. When it is high in state 0, the state goes to 1 and a connect pulse fires. A change on the raw sense input shows up 3 cycles after it is driven.
- R3: SE0 held for RESET_CYC consecutive synchronized cycles on a connected link fires one link-reset pulse and moves the state to 3, RESET_CYC+2 cycles after SE0 is driven. A shorter SE0 has no effect.
- R4: Idle J held for SUSPEND_CYC consecutive synchronized cycles fires a suspend pulse. The state moves to 2 from state 1, or to 4 from state 3, SUSPEND_CYC+2 cycles after J is driven.
- R5: Any non-J line condition in state 2 or 4 fires a resume pulse 3 cycles after it is driven. The state returns to 1 from state 2, or to 3 from state 4.
- R6: In state 3, HOSTLOST_CYC cycles without a valid SOF set the host-lost flag and fire exactly one host-lost pulse, counted from entry to state 3 or from the cycle after the last SOF.
- R7: A valid SOF clears the host-lost flag in the next cycle and restarts the SOF timer. Leaving state 3 also restarts the timer, so no host-lost pulse fires outside state 3.
- R8: With the override enable high, the override value replaces the raw sense input. It acts one cycle after it is driven, without the synchronizer delay. The sense status output always shows the effective level.
- R9: In state 0, SE0 and J on the line cause no event and no state change.
- R10: Every event pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz USB clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sense_i | input | 1 | Raw VBUS sense level (asynchronous) |
| sense_ovr_en_i | input | 1 | Selects the override value instead of the raw sense level |
| sense_ovr_val_i | input | 1 | Override sense level |
| line_se0_i | input | 1 | Decoded line condition: both data lines low (asynchronous) |
| line_j_i | input | 1 | Decoded line condition: idle J (asynchronous) |
| sof_valid_i | input | 1 | One-cycle strobe for a correctly received start-of-frame |
| link_state_o | output | 3 | Link state code (R1) |
| sense_o | output | 1 | Effective sense level |
| host_lost_o | output | 1 | Sticky host-lost flag |
| ev_connect_o | output | 1 | Connect pulse |
| ev_disconnect_o | output | 1 | Disconnect pulse |
| ev_link_reset_o | output | 1 | Link-reset pulse, also used to clear the device address |
| ev_suspend_o | output | 1 | Suspend pulse |
| ev_resume_o | output | 1 | Resume pulse |
| ev_host_lost_o | output | 1 | Host-lost pulse |

## Verification
Each result has a fixed due cycle, counted from the cycle in which the bench drives the stimulus.

| Result | Due after the stimulus |
|---|---|
| Connect, disconnect or resume from a raw sense or line change | 3 cycles |
| Link reset | RESET_CYC+2 cycles |
| Suspend | SUSPEND_CYC+2 cycles |
| Host-lost pulse | HOSTLOST_CYC cycles after entry to active, or HOSTLOST_CYC+1 cycles after the last SOF |
| Effect of an override change | 1 cycle |
| Host-lost flag clearing after an SOF | 1 cycle |

The driver works out each due cycle from the requirements and pushes the event kind and cycle into a queue. A monitor samples on the falling edge and pops the queue for every pulse it sees, so an event that is early, late, repeated or not expected is reported. State and flag checks are also sampled at the falling edge of the due cycle.

// File: rtl/usb_lmon_pkg.sv
package usb_lmon_pkg;

  typedef enum logic [2:0] {
    LS_DISC     = 3'd0,
    LS_POWERED  = 3'd1,
    LS_PWR_SUSP = 3'd2,
    LS_ACTIVE   = 3'd3,
    LS_SUSP     = 3'd4
  } link_state_e;

  // Suspend state entered from a given running state
  function automatic link_state_e suspend_target(input link_state_e s);
    return (s == LS_ACTIVE) ? LS_SUSP : LS_PWR_SUSP;
  endfunction

  // Running state restored on leaving a suspend state
  function automatic link_state_e resume_target(input link_state_e s);
    return (s == LS_SUSP) ? LS_ACTIVE : LS_POWERED;
  endfunction

  function automatic logic is_suspended(input link_state_e s);
    return (s == LS_PWR_SUSP) || (s == LS_SUSP);
  endfunction

  function automatic logic is_running(input link_state_e s);
    return (s == LS_POWERED) || (s == LS_ACTIVE);
  endfunction

endpackage

// File: rtl/lmon_sync.sv
module lmon_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= 2'b00;
      else         stage_q <= {stage_q[0], d_i[i]};
    end
    assign q_o[i] = stage_q[1];
  end

endmodule

// File: rtl/lmon_dwell.sv
// Counts consecutive cycles of cond_i; hit_o is high in the LIMIT-th such
// cycle only (the counter saturates so the hit does not repeat).
module lmon_dwell #(
  parameter int LIMIT = 144
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic hit_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] SAT  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign hit_o = cond_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!cond_i)     cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/usb_link_monitor.sv
module usb_link_monitor
  import usb_lmon_pkg::*;
#(
  parameter int RESET_CYC    = 144,
  parameter int SUSPEND_CYC  = 144000,
  parameter int HOSTLOST_CYC = 196608
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sense_i,
  input  logic       sense_ovr_en_i,
  input  logic       sense_ovr_val_i,
  input  logic       line_se0_i,
  input  logic       line_j_i,
  input  logic       sof_valid_i,
  output logic [2:0] link_state_o,
  output logic       sense_o,
  output logic       host_lost_o,
  output logic       ev_connect_o,
  output logic       ev_disconnect_o,
  output logic       ev_link_reset_o,
  output logic       ev_suspend_o,
  output logic       ev_resume_o,
  output logic       ev_host_lost_o
);

  // Synchronized inputs
  logic [2:0] raw_in, sync_in;
  logic sense_s, se0_s, j_s, sense_eff;

  assign raw_in = {sense_i, line_se0_i, line_j_i};

  lmon_sync #(.WIDTH(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign sense_s   = sync_in[2];
  assign se0_s     = sync_in[1];
  assign j_s       = sync_in[0] && !sync_in[1];
  assign sense_eff = sense_ovr_en_i ? sense_ovr_val_i : sense_s;

  link_state_e state_q, state_d;

  // Line timers
  logic reset_hit, susp_hit, hl_hit;

  lmon_dwell #(.LIMIT(RESET_CYC)) u_rst_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(se0_s && (state_q != LS_DISC)),
    .hit_o (reset_hit)
  );

  lmon_dwell #(.LIMIT(SUSPEND_CYC)) u_susp_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(j_s && is_running(state_q)),
    .hit_o (susp_hit)
  );

  lmon_dwell #(.LIMIT(HOSTLOST_CYC)) u_sof_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i((state_q == LS_ACTIVE) && !sof_valid_i),
    .hit_o (hl_hit)
  );

  // Link state machine
  logic conn_d, disc_d, rst_d, susp_d, res_d;

  always_comb begin
    state_d = state_q;
    conn_d  = 1'b0;
    disc_d  = 1'b0;
    rst_d   = 1'b0;
    susp_d  = 1'b0;
    res_d   = 1'b0;
    if (!sense_eff) begin
      if (state_q != LS_DISC) begin
        state_d = LS_DISC;
        disc_d  = 1'b1;
      end
    end else if (state_q == LS_DISC) begin
      state_d = LS_POWERED;
      conn_d  = 1'b1;
    end else if (reset_hit) begin
      state_d = LS_ACTIVE;
      rst_d   = 1'b1;
    end else if (is_suspended(state_q) && !j_s) begin
      state_d = resume_target(state_q);
      res_d   = 1'b1;
    end else if (susp_hit) begin
      state_d = suspend_target(state_q);
      susp_d  = 1'b1;
    end
  end

  logic hl_flag_q, hl_ev_q;
  logic [4:0] ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LS_DISC;
      ev_q      <= '0;
      hl_flag_q <= 1'b0;
      hl_ev_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ev_q    <= {res_d, susp_d, rst_d, disc_d, conn_d};
      hl_ev_q <= hl_hit;
      if (sof_valid_i)  hl_flag_q <= 1'b0;
      else if (hl_hit)  hl_flag_q <= 1'b1;
    end
  end

  assign link_state_o    = state_q;
  assign sense_o         = sense_eff;
  assign host_lost_o     = hl_flag_q;
  assign ev_connect_o    = ev_q[0];
  assign ev_disconnect_o = ev_q[1];
  assign ev_link_reset_o = ev_q[2];
  assign ev_suspend_o    = ev_q[3];
  assign ev_resume_o     = ev_q[4];
  assign ev_host_lost_o  = hl_ev_q;

endmodule

// File: rtl/usb_link_monitor_chk.sv
module usb_link_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sense_eff,
  input logic       sof_valid_i,
  input logic [2:0] link_state_o,
  input logic       host_lost_o,
  input logic       ev_connect_o,
  input logic       ev_disconnect_o,
  input logic       ev_link_reset_o,
  input logic       ev_suspend_o,
  input logic       ev_resume_o,
  input logic       ev_host_lost_o
);

  // R1
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_state_o <= 3'd4);

  // R2
  disc_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_eff && link_state_o != 3'd0) |=> (link_state_o == 3'd0) && ev_disconnect_o);

  // R2
  conn_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_connect_o |-> (link_state_o == 3'd1) && ($past(link_state_o) == 3'd0));

  // R3
  reset_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_link_reset_o |-> (link_state_o == 3'd3) && ($past(link_state_o) != 3'd0));

  // R4
  suspend_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_suspend_o |-> (link_state_o == 3'd2 && $past(link_state_o) == 3'd1) ||
                     (link_state_o == 3'd4 && $past(link_state_o) == 3'd3));

  // R5
  resume_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_resume_o |-> (link_state_o == 3'd1 && $past(link_state_o) == 3'd2) ||
                    (link_state_o == 3'd3 && $past(link_state_o) == 3'd4));

  // R6
  host_lost_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_host_lost_o |-> host_lost_o && ($past(link_state_o) == 3'd3));

  // R7
  sof_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_valid_i |=> !host_lost_o);

  // R10
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_connect_o || ev_disconnect_o || ev_link_reset_o || ev_suspend_o ||
     ev_resume_o || ev_host_lost_o) |=>
    !($past(ev_connect_o) && ev_connect_o) && !($past(ev_disconnect_o) && ev_disconnect_o) &&
    !($past(ev_link_reset_o) && ev_link_reset_o) && !($past(ev_suspend_o) && ev_suspend_o) &&
    !($past(ev_resume_o) && ev_resume_o) && !($past(ev_host_lost_o) && ev_host_lost_o));

endmodule

bind usb_link_monitor usb_link_monitor_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sense_eff      (sense_eff),
  .sof_valid_i    (sof_valid_i),
  .link_state_o   (link_state_o),
  .host_lost_o    (host_lost_o),
  .ev_connect_o   (ev_connect_o),
  .ev_disconnect_o(ev_disconnect_o),
  .ev_link_reset_o(ev_link_reset_o),
  .ev_suspend_o   (ev_suspend_o),
  .ev_resume_o    (ev_resume_o),
  .ev_host_lost_o (ev_host_lost_o)
);

// File: tb/tb_usb_link_monitor.sv
module tb_usb_link_monitor;

  localparam int CLK_PERIOD = 20;
  localparam int RST_N = 8;
  localparam int SUS_N = 40;
  localparam int HL_N  = 60;

  // event codes: 0 connect, 1 disconnect, 2 link reset, 3 suspend, 4 resume, 5 host lost
  typedef struct {
    int    code;
    int    due;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sense = 1'b0, ovr_en = 1'b0, ovr_val = 1'b0;
  logic se0 = 1'b0, jst = 1'b0, sof = 1'b0;
  logic [2:0] state;
  logic sense_st, hl_flag;
  logic e_conn, e_disc, e_rst, e_susp, e_res, e_hl;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_link_monitor #(
    .RESET_CYC(RST_N), .SUSPEND_CYC(SUS_N), .HOSTLOST_CYC(HL_N)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .sense_i(sense),
    .sense_ovr_en_i(ovr_en), .sense_ovr_val_i(ovr_val),
    .line_se0_i(se0), .line_j_i(jst), .sof_valid_i(sof),
    .link_state_o(state), .sense_o(sense_st), .host_lost_o(hl_flag),
    .ev_connect_o(e_conn), .ev_disconnect_o(e_disc), .ev_link_reset_o(e_rst),
    .ev_suspend_o(e_susp), .ev_resume_o(e_res), .ev_host_lost_o(e_hl)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic push(input int code, input int due, input string req);
    exp_t e;
    e.code = code; e.due = due; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every observed pulse must match the head of the queue
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] ev;
      ev = {e_hl, e_res, e_susp, e_rst, e_disc, e_conn};
      for (int i = 0; i < 6; i++) begin
        if (ev[i]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected event code", i, -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.code == i, e.req, "event code", i, e.code);
            chk(e.due == cyc, e.req, "event cycle", cyc, e.due);
          end
        end
      end
    end
  end

  initial begin
    int k;
    int a;
    int s;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(state == 3'd0, "R1", "state after reset", state, 0);
    chk(hl_flag == 1'b0, "R1", "host-lost flag after reset", hl_flag, 0);

    // R2 connect
    k = cyc; sense = 1'b1; push(0, k + 3, "R2");
    wait_until(k + 3);
    chk(state == 3'd1, "R2", "state after connect", state, 1);

    // R4 powered-suspend
    k = cyc; jst = 1'b1; push(3, k + SUS_N + 2, "R4");
    wait_until(k + SUS_N + 2);
    chk(state == 3'd2, "R4", "state powered-suspend", state, 2);

    // R5 resume to powered
    k = cyc; jst = 1'b0; push(4, k + 3, "R5");
    wait_until(k + 3);
    chk(state == 3'd1, "R5", "state after resume", state, 1);

    // R3 short SE0 is ignored
    se0 = 1'b1; step(3); se0 = 1'b0; step(RST_N + 5);
    chk(state == 3'd1, "R3", "state after short SE0", state, 1);

    // R3 long SE0 resets the link
    k = cyc; se0 = 1'b1; a = k + RST_N + 2; push(2, a, "R3");
    wait_until(a);
    chk(state == 3'd3, "R3", "state after link reset", state, 3);
    se0 = 1'b0;

    // R6 host lost, exactly once
    push(5, a + HL_N, "R6");
    wait_until(a + HL_N);
    chk(hl_flag == 1'b1, "R6", "host-lost flag set", hl_flag, 1);
    step(HL_N + 5);
    chk(hl_flag == 1'b1, "R6", "host-lost flag held", hl_flag, 1);

    // R7 SOF clears the flag
    s = cyc; sof = 1'b1; step(1); sof = 1'b0;
    chk(hl_flag == 1'b0, "R7", "host-lost flag after SOF", hl_flag, 0);

    // R4 suspend from active (before the restarted SOF timer expires)
    k = cyc; jst = 1'b1; push(3, k + SUS_N + 2, "R4");
    wait_until(k + SUS_N + 2);
    chk(state == 3'd4, "R4", "state suspended", state, 4);
    step(HL_N + 10); // R7: no host-lost while not active
    chk(hl_flag == 1'b0, "R7", "flag stays clear in suspend", hl_flag, 0);

    // R5 resume to active
    k = cyc; jst = 1'b0; push(4, k + 3, "R5");
    wait_until(k + 3);
    chk(state == 3'd3, "R5", "state after resume", state, 3);

    // R8 override forces disconnect without sync delay
    k = cyc; ovr_en = 1'b1; ovr_val = 1'b0; push(1, k + 1, "R8");
    wait_until(k + 1);
    chk(state == 3'd0, "R8", "state with override low", state, 0);
    chk(sense_st == 1'b0, "R8", "sense status with override low", sense_st, 0);
    k = cyc; ovr_val = 1'b1; push(0, k + 1, "R8");
    wait_until(k + 1);
    chk(state == 3'd1, "R8", "state with override high", state, 1);
    chk(sense_st == 1'b1, "R8", "sense status with override high", sense_st, 1);
    ovr_en = 1'b0; step(5);
    chk(state == 3'd1, "R8", "state after override release", state, 1);

    // R2 raw disconnect
    k = cyc; sense = 1'b0; push(1, k + 3, "R2");
    wait_until(k + 3);
    chk(state == 3'd0, "R2", "state after disconnect", state, 0);
    chk(sense_st == 1'b0, "R2", "sense status low", sense_st, 0);

    // R9 line activity ignored while disconnected
    se0 = 1'b1; step(RST_N + 10); se0 = 1'b0;
    jst = 1'b1; step(SUS_N + 10); jst = 1'b0; step(5);
    chk(state == 3'd0, "R9", "state stays disconnected", state, 0);

    step(5);
    chk(exp_q.size() == 0, "R10", "expected events not seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule